// File: doc/BRIEF.md
# PFC Protection and Startup Supervisor

This block decides when a boost power-factor-correction stage is allowed to switch. It receives a set of digital comparator flags: two for the supply rail (above the turn-on level, above the turn-off level) and five for the output-feedback pin, forming a thermometer of thresholds. The thresholds are open-loop/standby (0.8 V), output under-voltage (2.5 V), end of soft-start (4.0 V), and the lower (4.75 V) and upper (5.25 V) edges of the regulation window. Every flag is resynchronised through a two-stage flop chain before use.

A four-state machine sequences the stage. The states are OFF (supply lockout), STANDBY (feedback too low, open loop, or output under-voltage), SOFTSTART (switching with the low fixed source current selected) and RUN (normal regulation). The transitions are:
- power-up: OFF to STANDBY or SOFTSTART once the supply clears the turn-on level;
- lockout: any state to OFF when the supply drops below the turn-off level;
- open-loop: SOFTSTART or RUN to STANDBY on feedback below 0.8 V;
- under-voltage shutdown: RUN to STANDBY on feedback below 2.5 V;
- restart: STANDBY to SOFTSTART on feedback above 0.8 V;
- soft-start done: SOFTSTART to RUN on feedback at or above 4.0 V.

While the stage is switching, the block also raises fast requests to the gain stage: a duty-reduction request and window requests when feedback leaves the window around the setpoint. In both shutdown states the current-compensation node is clamped high.

Top module: `pfc_supervisor`

## Requirements
- R1: While reset is asserted, the state is OFF and all six outputs are 0.
- R2: Leaving OFF requires the supply flag above the turn-on level. With feedback above the open-loop level the block goes to SOFTSTART; otherwise it goes to STANDBY. Supply inside the hysteresis band (above turn-off, below turn-on) keeps the block in OFF.
- R3: In any state, the supply dropping below the turn-off level forces OFF with gate_en_o low. Supply inside the hysteresis band does not stop a running stage.
- R4: Feedback below the open-loop level moves SOFTSTART or RUN to STANDBY. STANDBY goes to SOFTSTART once feedback is back above the open-loop level.
- R5: In RUN, feedback below the under-voltage level moves the block to STANDBY.
- R6: In SOFTSTART, feedback below the under-voltage level (but above open-loop) is ignored; the state stays SOFTSTART.
- R7: SOFTSTART moves to RUN when feedback reaches the end-of-soft-start level. ss_sel_o is 1 exactly in SOFTSTART.
- R8: ovp_req_o is 1 when the stage is switching and feedback is above the upper window level.
- R9: While switching, win_uv_req_o is 1 for feedback below the lower window edge and win_ov_req_o is 1 above the upper edge. The two are never 1 together, and both are 0 when not switching.
- R10: A flag change reaches the outputs on the third rising clock edge after it is applied, not before.
- R11: gate_en_o is 1 exactly in SOFTSTART and RUN. icomp_force_o is 1 exactly in OFF and STANDBY (after reset). The two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sup_above_on_i | input | 1 | Supply above turn-on level (async) |
| sup_above_off_i | input | 1 | Supply above turn-off level (async) |
| fb_above_olp_i | input | 1 | Feedback above open-loop level (async) |
| fb_above_uv_i | input | 1 | Feedback above under-voltage level (async) |
| fb_above_ss_i | input | 1 | Feedback at/above end-of-soft-start level (async) |
| fb_above_lo_i | input | 1 | Feedback above lower window edge (async) |
| fb_above_hi_i | input | 1 | Feedback above upper window edge (async) |
| gate_en_o | output | 1 | Gate driver may switch |
| ss_sel_o | output | 1 | Select low fixed soft-start source current |
| icomp_force_o | output | 1 | Clamp current-compensation node high |
| ovp_req_o | output | 1 | Immediate duty-reduction request |
| win_uv_req_o | output | 1 | Fast response request, feedback below window |
| win_ov_req_o | output | 1 | Fast response request, feedback above window |

## Verification
Assertions watch every cycle for the lockout, under-voltage and soft-start hold transitions, for gate enable and compensation clamp never being active together, for the duty-reduction and window requests appearing only while switching, and for the two window requests never being active at once. Only the bench scenarios can show the full sequences: the hysteresis band holding OFF or holding RUN, restart from STANDBY, the exact three-edge latency of the synchronised path, and agreement with a reference model over random supply and feedback levels.

// File: rtl/pfc_sup_pkg.sv
package pfc_sup_pkg;

    typedef enum logic [1:0] {
        ST_OFF       = 2'd0,
        ST_STANDBY   = 2'd1,
        ST_SOFTSTART = 2'd2,
        ST_RUN       = 2'd3
    } sup_state_e;

    // Resynchronised comparator view, one bit per threshold
    typedef struct packed {
        logic sup_on;   // supply above turn-on level
        logic sup_ok;   // supply above turn-off level
        logic fb_olp;   // feedback above open-loop level
        logic fb_uv;    // feedback above under-voltage level
        logic fb_ss;    // feedback at/above end-of-soft-start
        logic fb_lo;    // feedback above lower window edge
        logic fb_hi;    // feedback above upper window edge
    } sense_t;

    localparam int SENSE_W = $bits(sense_t);

endpackage

// File: rtl/pfc_flag_sync.sv
module pfc_flag_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= '0;
                    else        chain_q[g] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= '0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[LAST];

endmodule

// File: rtl/pfc_seq_fsm.sv
module pfc_seq_fsm
    import pfc_sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sense_t     sense_i,
    output sup_state_e state_o,
    output logic       switching_nxt_o,
    output logic       gate_en_o,
    output logic       ss_sel_o,
    output logic       icomp_force_o
);
    sup_state_e state_q, state_d;
    logic       gate_q, ss_q, force_q;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (sense_i.sup_on)
                    state_d = sense_i.fb_olp ? ST_SOFTSTART : ST_STANDBY;
            end
            ST_STANDBY: begin
                if (!sense_i.sup_ok)     state_d = ST_OFF;
                else if (sense_i.fb_olp) state_d = ST_SOFTSTART;
            end
            ST_SOFTSTART: begin
                if (!sense_i.sup_ok)      state_d = ST_OFF;
                else if (!sense_i.fb_olp) state_d = ST_STANDBY;
                else if (sense_i.fb_ss)   state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!sense_i.sup_ok)                         state_d = ST_OFF;
                else if (!sense_i.fb_olp || !sense_i.fb_uv)  state_d = ST_STANDBY;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Output register, decoded from the upcoming state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q  <= 1'b0;
            ss_q    <= 1'b0;
            force_q <= 1'b0;
        end else begin
            unique case (state_d)
                ST_OFF, ST_STANDBY: begin
                    gate_q  <= 1'b0;
                    ss_q    <= 1'b0;
                    force_q <= 1'b1;
                end
                ST_SOFTSTART: begin
                    gate_q  <= 1'b1;
                    ss_q    <= 1'b1;
                    force_q <= 1'b0;
                end
                ST_RUN: begin
                    gate_q  <= 1'b1;
                    ss_q    <= 1'b0;
                    force_q <= 1'b0;
                end
                default: begin
                    gate_q  <= 1'b0;
                    ss_q    <= 1'b0;
                    force_q <= 1'b1;
                end
            endcase
        end
    end

    assign state_o         = state_q;
    assign switching_nxt_o = (state_d == ST_SOFTSTART) || (state_d == ST_RUN);
    assign gate_en_o       = gate_q;
    assign ss_sel_o        = ss_q;
    assign icomp_force_o   = force_q;

    // R3
    lockout_to_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sense_i.sup_ok |=> (state_q == ST_OFF) && !gate_q);

    // R2
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) && !sense_i.sup_on |=> state_q == ST_OFF);

    // R5
    run_uv_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) && sense_i.sup_ok && !sense_i.fb_uv |=> state_q == ST_STANDBY);

    // R6
    soft_uv_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SOFTSTART) && sense_i.sup_ok && sense_i.fb_olp && !sense_i.fb_ss
        |=> state_q == ST_SOFTSTART);

    // R4
    standby_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STANDBY) && sense_i.sup_ok && sense_i.fb_olp |=> state_q == ST_SOFTSTART);

endmodule

// File: rtl/pfc_window_req.sv
module pfc_window_req
    import pfc_sup_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  sense_t sense_i,
    input  logic   switching_i,
    output logic   ovp_req_o,
    output logic   win_uv_req_o,
    output logic   win_ov_req_o
);
    logic ovp_q, wuv_q, wov_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovp_q <= 1'b0;
            wuv_q <= 1'b0;
            wov_q <= 1'b0;
        end else begin
            ovp_q <= switching_i && sense_i.fb_hi;
            wuv_q <= switching_i && !sense_i.fb_lo;
            wov_q <= switching_i && sense_i.fb_hi;
        end
    end

    assign ovp_req_o    = ovp_q;
    assign win_uv_req_o = wuv_q;
    assign win_ov_req_o = wov_q;

endmodule

// File: rtl/pfc_supervisor.sv
module pfc_supervisor
    import pfc_sup_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_above_on_i,
    input  logic sup_above_off_i,
    input  logic fb_above_olp_i,
    input  logic fb_above_uv_i,
    input  logic fb_above_ss_i,
    input  logic fb_above_lo_i,
    input  logic fb_above_hi_i,
    output logic gate_en_o,
    output logic ss_sel_o,
    output logic icomp_force_o,
    output logic ovp_req_o,
    output logic win_uv_req_o,
    output logic win_ov_req_o
);
    logic [SENSE_W-1:0] raw_flags, sync_flags;
    sense_t             sense;
    sup_state_e         state;
    logic               switching_nxt;

    assign raw_flags = {sup_above_on_i, sup_above_off_i, fb_above_olp_i, fb_above_uv_i,
                        fb_above_ss_i, fb_above_lo_i, fb_above_hi_i};

    pfc_flag_sync #(.W(SENSE_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_flags),
        .sync_o  (sync_flags)
    );

    assign sense = sense_t'(sync_flags);

    pfc_seq_fsm i_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .sense_i         (sense),
        .state_o         (state),
        .switching_nxt_o (switching_nxt),
        .gate_en_o       (gate_en_o),
        .ss_sel_o        (ss_sel_o),
        .icomp_force_o   (icomp_force_o)
    );

    pfc_window_req i_win (
        .clk          (clk),
        .rst_n        (rst_n),
        .sense_i      (sense),
        .switching_i  (switching_nxt),
        .ovp_req_o    (ovp_req_o),
        .win_uv_req_o (win_uv_req_o),
        .win_ov_req_o (win_ov_req_o)
    );

    // R11
    gate_force_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_en_o && icomp_force_o));

    // R8
    ovp_needs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_req_o |-> gate_en_o);

    // R9
    window_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({win_uv_req_o, win_ov_req_o}) <= 1);

    // R9
    window_needs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_uv_req_o || win_ov_req_o) |-> gate_en_o);

    // R7
    ss_in_soft_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_sel_o |-> (state == ST_SOFTSTART));

endmodule

// File: tb/test_pfc_supervisor.sv
module test_pfc_supervisor;

    localparam int ST_OFF = 0, ST_SB = 1, ST_SS = 2, ST_RUN = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sup_on = 1'b0, sup_ok = 1'b0;
    logic f_olp = 1'b0, f_uv = 1'b0, f_ss = 1'b0, f_lo = 1'b0, f_hi = 1'b0;
    logic gate, ss, force_h, ovp, wuv, wov;

    int total = 0;
    int bad   = 0;
    int mstate = ST_OFF;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pfc_supervisor i_pfc_supervisor (
        .clk(clk), .rst_n(rst_n),
        .sup_above_on_i(sup_on), .sup_above_off_i(sup_ok),
        .fb_above_olp_i(f_olp), .fb_above_uv_i(f_uv), .fb_above_ss_i(f_ss),
        .fb_above_lo_i(f_lo), .fb_above_hi_i(f_hi),
        .gate_en_o(gate), .ss_sel_o(ss), .icomp_force_o(force_h),
        .ovp_req_o(ovp), .win_uv_req_o(wuv), .win_ov_req_o(wov)
    );

    // Supply level: 0 below turn-off, 1 hysteresis band, 2 above turn-on.
    // Feedback level: 0 <olp, 1 olp..uv, 2 uv..ss, 3 ss..lo, 4 in window, 5 above hi.
    function automatic int step(int st, int s, int f);
        case (st)
            ST_OFF:  return (s == 2) ? ((f >= 1) ? ST_SS : ST_SB) : ST_OFF;
            ST_SB:   return (s == 0) ? ST_OFF : ((f >= 1) ? ST_SS : ST_SB);
            ST_SS:   return (s == 0) ? ST_OFF : (f == 0) ? ST_SB : (f >= 3) ? ST_RUN : ST_SS;
            default: return (s == 0) ? ST_OFF : (f <= 1) ? ST_SB : ST_RUN;
        endcase
    endfunction

    function automatic logic [5:0] outs(int st, int f);
        logic on;
        on = (st == ST_SS) || (st == ST_RUN);
        return {on, st == ST_SS, !on, on && f == 5, on && f < 4, on && f == 5};
    endfunction

    task automatic drive(int s, int f);
        sup_on = (s == 2); sup_ok = (s >= 1);
        f_olp = (f >= 1); f_uv = (f >= 2); f_ss = (f >= 3); f_lo = (f >= 4); f_hi = (f >= 5);
    endtask

    task automatic chk(string req, logic [5:0] got, logic [5:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%b exp=%b (gate,ss,force,ovp,wuv,wov)", req, got, exp);
        end
    endtask

    // Apply levels at a falling edge, hold, then compare against the model.
    task automatic apply(int s, int f, string req);
        drive(s, f);
        repeat (6) @(negedge clk);
        for (int k = 0; k < 6; k++) mstate = step(mstate, s, f);
        chk(req, {gate, ss, force_h, ovp, wuv, wov}, outs(mstate, f));
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        drive(2, 4);
        repeat (3) @(negedge clk);
        chk("R1 reset", {gate, ss, force_h, ovp, wuv, wov}, 6'b000000);
        rst_n = 1'b1;

        apply(1, 3, "R2 hysteresis band keeps OFF");
        apply(2, 0, "R2 on without feedback -> STANDBY");
        apply(2, 1, "R4 restart to SOFTSTART");
        apply(2, 1, "R6 under-voltage ignored in SOFTSTART");
        apply(2, 2, "R7 below ss end stays SOFTSTART");
        apply(2, 3, "R7 ss end -> RUN");
        apply(2, 1, "R5 RUN under-voltage -> STANDBY");
        apply(2, 2, "R4 standby restart");
        apply(2, 4, "R11 RUN in window");
        apply(1, 4, "R3 band does not stop RUN");

        // R10 latency: in RUN, feedback goes above window
        drive(1, 5);
        @(negedge clk);
        @(negedge clk);
        chk("R10 no change after two edges", {gate, ss, force_h, ovp, wuv, wov}, outs(ST_RUN, 4));
        @(negedge clk);
        chk("R10 change on third edge", {gate, ss, force_h, ovp, wuv, wov}, outs(ST_RUN, 5));
        apply(1, 5, "R8 overvoltage request");
        apply(2, 3, "R9 below window request");
        apply(0, 4, "R3 lockout -> OFF");
        apply(2, 4, "R2 both conditions -> SOFTSTART then RUN");
        apply(2, 0, "R4 open loop -> STANDBY");

        for (int i = 0; i < 400; i++) begin
            int s, f;
            s = ($urandom % 10 < 7) ? 2 : int'($urandom % 2);
            f = int'($urandom % 6);
            apply(s, f, "R11 random");
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule